// File: doc/BRIEF.md
# Configurable Link Fault Injector

This block sits in series with a bundle of wires between two routers, or inside a crossbar path. It registers the bus and passes it through unchanged unless a fault is armed. When a fault is armed, one fault model is applied to one chosen wire, or to a chosen pair of wires for a bridge. The output is the possibly corrupted bus. The available models are:

- inverting the wire;
- holding it at 0 or at 1, as an open segment does;
- letting a driver wire override a victim wire, as a bridge does;
- adding a chosen number of cycles of delay to the wire.

A controller arms or changes the fault only while the surrounding network is frozen. To do so it presents the configuration together with a load strobe. A strobe given while the freeze input is low has no effect. Short pulses on a wire are not modelled here; they belong to a separate flip-flop upset model.

Top module: `link_fault_injector`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bus_out` is all zeros. After reset the stored fault is disarmed, type 0.
- R2: When the stored enable is 0, or the stored type is 0 (none), 6 or 7, `bus_out` equals `bus_in` delayed by exactly one clock.
- R3: Type 1 (invert) drives the wire named by `fault_wire` with the inverse of its input one clock later. All other wires pass through with one clock of latency.
- R4: Type 2 (stuck-at-0) forces the selected wire of `bus_out` to 0. All other wires pass through.
- R5: Type 3 (stuck-at-1) forces the selected wire of `bus_out` to 1. All other wires pass through.
- R6: Type 4 (bridge) replaces the wire named by `fault_peer` with the current value of the wire named by `fault_wire`. The driver wire and all other wires pass through.
- R7: Type 4 with `fault_wire` equal to `fault_peer` leaves the whole bus unchanged, with one clock of latency.
- R8: Type 5 (delay) with depth d, where 0 to 7 is set by `fault_delay`, drives the selected wire with its input from d+1 clocks earlier. Depth 0 gives the normal one-clock latency. Delay history before reset is taken as 0.
- R9: A configuration is stored only on a clock edge where `cfg_load` and `freeze` are both high. A strobe while `freeze` is low leaves the stored fault, and therefore `bus_out`, unchanged.
- R10: A configuration stored on edge k first shapes the `bus_out` value produced on edge k+1. Except in delay mode, at most one wire of `bus_out` differs from the previous cycle's `bus_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | High while the network is halted; gates configuration loads |
| cfg_load | input | 1 | Load strobe for the fault configuration |
| fault_en | input | 1 | Arm the fault |
| fault_type | input | 3 | Fault model code: 0 none, 1 invert, 2 stuck-0, 3 stuck-1, 4 bridge, 5 delay, 6 and 7 none |
| fault_wire | input | $clog2(WIDTH) | Selected wire; for a bridge, this wire is the driver |
| fault_peer | input | $clog2(WIDTH) | Victim wire for a bridge |
| fault_delay | input | $clog2(MAX_DELAY+1) | Extra delay depth, in cycles |
| bus_in | input | WIDTH | Original bus |
| bus_out | output | WIDTH | Registered, possibly faulted bus |

## Verification
Every `bus_out` value is due one edge after the `bus_in` value it comes from. A wire under a delay fault of depth d instead shows its input from d+1 edges earlier. A loaded configuration first shows up one edge after the edge that stored it.

The bench drives inputs on the falling edge. It updates a behavioural model on each rising edge, using a history of past inputs and a copy of the configuration that follows the freeze rule. It compares the whole bus shortly after each falling edge, so every expected value already includes the register stages above. The checks made in the cycles right after a load are tagged to the load-timing requirement.

// File: rtl/lfi_pkg.sv
package lfi_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    FK_NONE   = 3'd0,
    FK_INVERT = 3'd1,
    FK_STUCK0 = 3'd2,
    FK_STUCK1 = 3'd3,
    FK_BRIDGE = 3'd4,
    FK_DELAY  = 3'd5
  } fault_kind_e;
endpackage

// File: rtl/lfi_cfg_reg.sv
module lfi_cfg_reg
  import lfi_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int DLY_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic              load,
  input  logic              en_d,
  input  logic [KIND_W-1:0] kind_d,
  input  logic [IDX_W-1:0]  wa_d,
  input  logic [IDX_W-1:0]  wb_d,
  input  logic [DLY_W-1:0]  dly_d,
  output logic              en_q,
  output logic [KIND_W-1:0] kind_q,
  output logic [IDX_W-1:0]  wa_q,
  output logic [IDX_W-1:0]  wb_q,
  output logic [DLY_W-1:0]  dly_q
);
  logic take;
  assign take = load & freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      kind_q <= FK_NONE;
      wa_q   <= '0;
      wb_q   <= '0;
      dly_q  <= '0;
    end else if (take) begin
      en_q   <= en_d;
      kind_q <= kind_d;
      wa_q   <= wa_d;
      wb_q   <= wb_d;
      dly_q  <= dly_d;
    end
  end

  // R9: a strobe outside a freeze leaves the stored fault alone
  a_r9_load_gated: assert property (@(posedge clk) disable iff (rst)
    !(load && freeze) |=> $stable({en_q, kind_q, wa_q, wb_q, dly_q}));

  // R9: an accepted strobe stores the presented configuration
  a_r9_load_taken: assert property (@(posedge clk) disable iff (rst)
    (load && freeze) |=> ({en_q, kind_q, wa_q, wb_q, dly_q} ==
                          $past({en_d, kind_d, wa_d, wb_d, dly_d})));
endmodule

// File: rtl/lfi_delay_lane.sv
module lfi_delay_lane #(
  parameter int MAX_DELAY = 7,
  parameter int DLY_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [DLY_W-1:0] depth,
  output logic             tap
);
  logic [MAX_DELAY-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[MAX_DELAY-2:0], din};
  end

  always_comb begin
    if (depth == '0)
      tap = din;
    else if (int'(depth) > MAX_DELAY)
      tap = sr[MAX_DELAY-1];
    else
      tap = sr[int'(depth)-1];
  end
endmodule

// File: rtl/lfi_fault_apply.sv
module lfi_fault_apply
  import lfi_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IDX_W = 5
) (
  input  logic [WIDTH-1:0]  bus,
  input  logic [WIDTH-1:0]  late,
  input  logic              en,
  input  logic [KIND_W-1:0] kind,
  input  logic [IDX_W-1:0]  wa,
  input  logic [IDX_W-1:0]  wb,
  output logic [WIDTH-1:0]  faulted
);
  logic [WIDTH-1:0] sel_a;
  logic [WIDTH-1:0] sel_b;
  logic             drv;

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign sel_a[i] = (wa == IDX_W'(i));
    assign sel_b[i] = (wb == IDX_W'(i));
  end

  assign drv = |(bus & sel_a);

  for (genvar i = 0; i < WIDTH; i++) begin : g_wire
    always_comb begin
      faulted[i] = bus[i];
      if (en) begin
        case (kind)
          FK_INVERT: if (sel_a[i]) faulted[i] = ~bus[i];
          FK_STUCK0: if (sel_a[i]) faulted[i] = 1'b0;
          FK_STUCK1: if (sel_a[i]) faulted[i] = 1'b1;
          FK_BRIDGE: if (sel_b[i] && !sel_a[i]) faulted[i] = drv;
          FK_DELAY:  if (sel_a[i]) faulted[i] = late[i];
          default:   faulted[i] = bus[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/link_fault_injector.sv
module link_fault_injector
  import lfi_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int MAX_DELAY = 7,
  localparam int IDX_W    = $clog2(WIDTH),
  localparam int DLY_W    = $clog2(MAX_DELAY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic              cfg_load,
  input  logic              fault_en,
  input  logic [KIND_W-1:0] fault_type,
  input  logic [IDX_W-1:0]  fault_wire,
  input  logic [IDX_W-1:0]  fault_peer,
  input  logic [DLY_W-1:0]  fault_delay,
  input  logic [WIDTH-1:0]  bus_in,
  output logic [WIDTH-1:0]  bus_out
);
  logic              en_q;
  logic [KIND_W-1:0] kind_q;
  logic [IDX_W-1:0]  wa_q;
  logic [IDX_W-1:0]  wb_q;
  logic [DLY_W-1:0]  dly_q;
  logic [WIDTH-1:0]  late;
  logic [WIDTH-1:0]  faulted;

  lfi_cfg_reg #(.IDX_W(IDX_W), .DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rst(rst), .freeze(freeze), .load(cfg_load),
    .en_d(fault_en), .kind_d(fault_type), .wa_d(fault_wire),
    .wb_d(fault_peer), .dly_d(fault_delay),
    .en_q(en_q), .kind_q(kind_q), .wa_q(wa_q), .wb_q(wb_q), .dly_q(dly_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    lfi_delay_lane #(.MAX_DELAY(MAX_DELAY), .DLY_W(DLY_W)) u_lane (
      .clk(clk), .rst(rst), .din(bus_in[i]), .depth(dly_q), .tap(late[i])
    );
  end

  lfi_fault_apply #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_apply (
    .bus(bus_in), .late(late), .en(en_q), .kind(kind_q),
    .wa(wa_q), .wb(wb_q), .faulted(faulted)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_out <= '0;
    else     bus_out <= faulted;
  end

  // Cycles seen since reset, used only to keep $past inside the post-reset window
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic quiet;
  assign quiet = !en_q || !(kind_q inside {FK_INVERT, FK_STUCK0, FK_STUCK1, FK_BRIDGE, FK_DELAY});

  // R2: a disarmed or unknown fault is a plain one-cycle pipe
  a_r2_pass: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && quiet) |=> bus_out == $past(bus_in));

  // R3: the selected wire comes out inverted
  a_r3_invert: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && en_q && kind_q == FK_INVERT) |=>
      bus_out == ($past(bus_in) ^ (WIDTH'(1) << $past(wa_q))));

  // R4: the selected wire is held low
  a_r4_stuck0: assert property (@(posedge clk) disable iff (rst)
    (en_q && kind_q == FK_STUCK0) |=> !bus_out[$past(wa_q)]);

  // R5: the selected wire is held high
  a_r5_stuck1: assert property (@(posedge clk) disable iff (rst)
    (en_q && kind_q == FK_STUCK1) |=> bus_out[$past(wa_q)]);

  // R6: the victim wire repeats the driver wire
  a_r6_bridge: assert property (@(posedge clk) disable iff (rst)
    (en_q && kind_q == FK_BRIDGE) |=> bus_out[$past(wb_q)] == bus_out[$past(wa_q)]);

  // R8: a one-cycle delay fault shows the input from two cycles back
  a_r8_delay1: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && en_q && kind_q == FK_DELAY && dly_q == DLY_W'(1)) |=>
      bus_out[$past(wa_q)] == $past(bus_in[wa_q], 2));

  // R10: outside delay mode at most one wire differs from the input
  a_r10_single_wire: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !(en_q && kind_q == FK_DELAY)) |=>
      $countones(bus_out ^ $past(bus_in)) <= 1);
endmodule

// File: tb/test_link_fault_injector.sv
`timescale 1ns/1ps
module test_link_fault_injector;
  localparam int W  = 32;
  localparam int MD = 7;
  localparam int IW = 5;
  localparam int DW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          freeze = 1'b0;
  logic          cfg_load = 1'b0;
  logic          fault_en = 1'b0;
  logic [2:0]    fault_type = 3'd0;
  logic [IW-1:0] fault_wire = '0;
  logic [IW-1:0] fault_peer = '0;
  logic [DW-1:0] fault_delay = '0;
  logic [W-1:0]  bus_in = '0;
  logic [W-1:0]  bus_out;

  always #2 clk = ~clk;

  link_fault_injector i_link_fault_injector (
    .clk(clk), .rst(rst), .freeze(freeze), .cfg_load(cfg_load),
    .fault_en(fault_en), .fault_type(fault_type), .fault_wire(fault_wire),
    .fault_peer(fault_peer), .fault_delay(fault_delay),
    .bus_in(bus_in), .bus_out(bus_out)
  );

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    started = 0;
  bit    done = 0;
  string tag = "R1";

  // Behavioural reference: stored configuration plus an input history
  bit           m_en;
  int           m_kind, m_a, m_b, m_d;
  logic [W-1:0] hist [1:MD];
  logic [W-1:0] exp_out;

  function automatic logic [W-1:0] model_next(logic [W-1:0] cur);
    logic [W-1:0] r = cur;
    if (m_en) begin
      case (m_kind)
        1: r[m_a] = ~cur[m_a];
        2: r[m_a] = 1'b0;
        3: r[m_a] = 1'b1;
        4: if (m_a != m_b) r[m_b] = cur[m_a];
        5: r[m_a] = (m_d == 0) ? cur[m_a] : hist[m_d][m_a];
        default: r = cur;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    cycles++;
    if (rst) begin
      exp_out = '0;
      m_en = 0; m_kind = 0; m_a = 0; m_b = 0; m_d = 0;
      for (int k = 1; k <= MD; k++) hist[k] = '0;
    end else begin
      exp_out = model_next(bus_in);
      if (cfg_load && freeze) begin
        m_en = fault_en; m_kind = int'(fault_type);
        m_a = int'(fault_wire); m_b = int'(fault_peer); m_d = int'(fault_delay);
      end
      for (int k = MD; k > 1; k--) hist[k] = hist[k-1];
      hist[1] = bus_in;
    end
  end

  always @(negedge clk) begin
    #1;
    if (started && !done) begin
      checks++;
      if (bus_out !== exp_out) begin
        failures++;
        $display("FAIL %s: bus_out=%h expected=%h", tag, bus_out, exp_out);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  task automatic run(string t, int n);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_in = $urandom();
    end
  endtask

  task automatic load(bit frz, bit en, int kind, int a, int b, int d, string t);
    @(negedge clk);
    freeze = frz; cfg_load = 1'b1; fault_en = en;
    fault_type = 3'(kind); fault_wire = IW'(a); fault_peer = IW'(b);
    fault_delay = DW'(d); bus_in = $urandom();
    @(negedge clk);
    cfg_load = 1'b0; freeze = 1'b0;
    tag = "R10";  // first outputs shaped by the new configuration
    bus_in = $urandom();
    @(negedge clk);
    bus_in = $urandom();
    tag = t;
  endtask

  initial begin
    // R1: reset state, held with a busy input
    bus_in = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run("R1", 1);
    run("R2", 20);
    // R9: strobe without freeze is ignored; output stays plain
    load(0, 1, 1, 4, 0, 0, "R9");
    run("R9", 10);
    load(1, 1, 1, 4, 0, 0, "R3");
    run("R3", 20);
    load(1, 1, 1, 31, 0, 0, "R3");
    run("R3", 10);
    load(1, 1, 2, 0, 0, 0, "R4");
    bus_in = '1; run("R4", 10);
    load(1, 1, 3, 17, 0, 0, "R5");
    run("R5", 10);
    load(1, 1, 4, 3, 9, 0, "R6");
    run("R6", 20);
    load(1, 1, 4, 9, 3, 0, "R6");
    run("R6", 10);
    load(1, 1, 4, 12, 12, 0, "R7");
    run("R7", 15);
    load(1, 1, 5, 6, 0, 0, "R8");
    run("R8", 10);
    load(1, 1, 5, 6, 0, 3, "R8");
    run("R8", 20);
    load(1, 1, 5, 30, 0, 7, "R8");
    run("R8", 20);
    load(1, 1, 6, 5, 0, 0, "R2");
    run("R2", 10);
    load(1, 1, 7, 5, 0, 0, "R2");
    run("R2", 10);
    load(1, 0, 1, 5, 0, 0, "R2");
    run("R2", 10);
    load(1, 1, 3, 8, 0, 0, "R5");
    load(0, 1, 0, 0, 0, 0, "R9");
    run("R9", 10);
    // R1: reset again while faulted
    @(negedge clk); rst = 1'b1; tag = "R1";
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run("R1", 1);
    run("R2", 5);
    finish_run();
  end
endmodule